// File: doc/BRIEF.md
# Fully Associative Cache with Load-Order Replacement

This block is a small cache in which any memory line may sit in any entry. A request address is split into two fields only: a tag in the upper bits and a word offset in the lower bits. There is no index field. Every entry has its own tag comparator. All valid tags are checked against the request tag in one cycle, and a read that matches returns the word straight from the line store.

On a read miss, the line is fetched from main memory one word at a time and written into an entry. The block picks that entry in one of two ways:

- While any entry is still empty, it uses the lowest-numbered empty entry.
- Once every entry holds a line, it evicts the entry whose line was loaded earliest.

The load order moves forward only when a line fill finishes, so hits never change which entry goes next. Writes follow the write-through rule. A write that hits updates the cached word and also issues the same write to memory. A write that misses goes to memory only and allocates nothing.

Every request ends with a single response beat. That beat carries the hit or miss result, the entry used, whether a valid line was evicted, and the read data.

A state machine sequences each request through five states:

| State | What happens | Next state |
|---|---|---|
| `ST_IDLE` | Ready for a request. | `ST_LOOKUP` when a request arrives |
| `ST_LOOKUP` | Parallel tag compare. | `ST_WRITE` for any write; `ST_DONE` for a read hit; `ST_FILL` for a read miss |
| `ST_FILL` | Word-by-word line fetch. | `ST_DONE` after the last word is accepted |
| `ST_WRITE` | Memory write beat. | `ST_DONE` |
| `ST_DONE` | Response beat. | `ST_IDLE` |

Top module: `assoc_fifo_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `mem_rd_req` and `mem_wr_en` are 0. All entries are empty, so the first read misses into entry 0 with `resp_repl`=0.
- R2: The tag is `req_addr[ADDR_W-1:ADDR_W-TAG_W]` and the word offset is the remaining low bits. Two addresses with the same tag and different offsets hit the same line.
- R3: A read whose tag equals the tag of any valid entry reports `resp_hit`=1. `resp_entry` is that entry and `resp_rdata` is the stored word at the offset. No memory access is made.
- R4: A read miss while an empty entry exists fills the lowest-numbered empty entry and reports `resp_repl`=0.
- R5: A read miss with all entries valid replaces the entry loaded earliest, reports `resp_repl`=1, and never reports `resp_repl`=1 together with `resp_hit`=1.
- R6: Hits do not change the replacement order. Only a completed line fill advances it, and it wraps modulo `ENTRIES`.
- R7: A fill holds `mem_rd_req` high and reads addresses {tag, 0} up to {tag, WORDS-1} in ascending order. It advances one word per cycle in which `mem_rd_valid` is 1, and holds the address while `mem_rd_valid` is 0. The response returns the word at the requested offset.
- R8: A write hit updates the cached word, so a later read hit returns the new data. It issues exactly one `mem_wr_en` beat with the full address and data, and reports `resp_hit`=1 with the hit entry.
- R9: A write miss issues exactly one memory write and reports `resp_hit`=0 and `resp_repl`=0. It allocates no entry and leaves the replacement order untouched.
- R10: Reads of 010A, 011A, 012F, 011B, 023F, 012C, 030F (hex) give: miss, miss, miss, hit, miss, hit, and finally a miss that replaces entry 0, which holds tag 010.
- R11: `req_ready` is 1 only when the block is idle. Each request produces exactly one single-cycle `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: tag, then offset |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response beat |
| resp_hit | output | 1 | Tag matched a valid entry |
| resp_repl | output | 1 | A valid line was evicted for this fill |
| resp_entry | output | IDX_W | Entry hit or filled |
| resp_rdata | output | DATA_W | Read word (echoes write data for writes) |
| mem_rd_req | output | 1 | Fill read request |
| mem_rd_addr | output | ADDR_W | Fill read word address |
| mem_rd_valid | input | 1 | Fill word returned for `mem_rd_addr` |
| mem_rd_data | input | DATA_W | Fill word |
| mem_wr_en | output | 1 | Write-through beat |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
A fault in an entry's valid bit or stored tag shows up on the very next request to that line. That request reports the wrong `resp_hit` or `resp_entry`, and a false miss also starts an unexpected run of `mem_rd_req` beats.

A fault in the replacement pointer stays hidden while empty entries remain. It first appears on the next eviction, as a wrong `resp_entry`. Its full effect appears on a later read of the line that should have stayed cached, which then misses instead of hitting.

A fault in the fill sequencer shows on the memory port within one word. It appears as an out-of-order or repeated `mem_rd_addr`, or as stale data returned on a later hit.

// File: rtl/acache_pkg.sv
package acache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_WRITE,
        ST_DONE
    } cache_state_e;

endpackage

// File: rtl/acache_tag_cam.sv
module acache_tag_cam #(
    parameter int TAG_W   = 12,
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0]            valid_i,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]              tag_i,
    output logic                          hit_o,
    output logic [IDX_W-1:0]              hit_idx_o
);

    logic [ENTRIES-1:0] match;

    // one comparator per entry, all evaluated in the same cycle
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    always_comb begin
        hit_idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_idx_o = IDX_W'(i);
            end
        end
        hit_o = |match;
    end

endmodule

// File: rtl/acache_fifo_victim.sv
module acache_fifo_victim #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_i,
    input  logic               advance_i,
    output logic [IDX_W-1:0]   victim_o,
    output logic               evict_o
);

    logic [IDX_W-1:0] load_ptr;
    logic [IDX_W-1:0] free_idx;

    // load-order pointer: moves only when a fill completes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_ptr <= '0;
        end else if (advance_i) begin
            if (load_ptr == IDX_W'(ENTRIES - 1)) begin
                load_ptr <= '0;
            end else begin
                load_ptr <= load_ptr + 1'b1;
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign evict_o  = &valid_i;
    assign victim_o = evict_o ? load_ptr : free_idx;

endmodule

// File: rtl/acache_line_ram.sv
module acache_line_ram #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 16,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = 2,
    parameter int OFF_W   = 4
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  wentry_i,
    input  logic [OFF_W-1:0]  woff_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  rentry_i,
    input  logic [OFF_W-1:0]  roff_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] cells [ENTRIES][WORDS];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells[wentry_i][woff_i] <= wdata_i;
        end
    end

    assign rdata_o = cells[rentry_i][roff_i];

endmodule

// File: rtl/assoc_fifo_cache.sv
module assoc_fifo_cache
    import acache_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int TAG_W   = 12,
    parameter int ENTRIES = 4,
    parameter int DATA_W  = 8,
    localparam int OFF_W  = ADDR_W - TAG_W,
    localparam int WORDS  = 1 << OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_repl,
    output logic [IDX_W-1:0]  resp_entry,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    cache_state_e state, state_nxt;

    // captured request
    logic              q_write;
    logic [TAG_W-1:0]  q_tag;
    logic [OFF_W-1:0]  q_off;
    logic [DATA_W-1:0] q_wdata;

    // directory
    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_arr;

    // fill bookkeeping
    logic [OFF_W-1:0] fill_cnt;
    logic [IDX_W-1:0] tgt_entry;
    logic             fill_last;
    logic             advance;

    // response registers
    logic              r_hit;
    logic              r_repl;
    logic [IDX_W-1:0]  r_entry;
    logic [DATA_W-1:0] r_rdata;

    // sub-block nets
    logic              cam_hit;
    logic [IDX_W-1:0]  cam_idx;
    logic [IDX_W-1:0]  vic_idx;
    logic              vic_evict;
    logic              ram_we;
    logic [IDX_W-1:0]  ram_wentry;
    logic [OFF_W-1:0]  ram_woff;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_rdata;

    acache_tag_cam #(
        .TAG_W   (TAG_W),
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_cam (
        .valid_i   (valid_vec),
        .tags_i    (tag_arr),
        .tag_i     (q_tag),
        .hit_o     (cam_hit),
        .hit_idx_o (cam_idx)
    );

    acache_fifo_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (valid_vec),
        .advance_i (advance),
        .victim_o  (vic_idx),
        .evict_o   (vic_evict)
    );

    acache_line_ram #(
        .ENTRIES (ENTRIES),
        .WORDS   (WORDS),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W),
        .OFF_W   (OFF_W)
    ) u_ram (
        .clk      (clk),
        .we_i     (ram_we),
        .wentry_i (ram_wentry),
        .woff_i   (ram_woff),
        .wdata_i  (ram_wdata),
        .rentry_i (cam_idx),
        .roff_i   (q_off),
        .rdata_o  (ram_rdata)
    );

    assign fill_last = mem_rd_valid && (&fill_cnt);
    assign advance   = (state == ST_FILL) && fill_last;

    // line store write port: write-hit update or fill word
    always_comb begin
        ram_we     = 1'b0;
        ram_wentry = tgt_entry;
        ram_woff   = fill_cnt;
        ram_wdata  = mem_rd_data;
        if (state == ST_LOOKUP && q_write && cam_hit) begin
            ram_we     = 1'b1;
            ram_wentry = cam_idx;
            ram_woff   = q_off;
            ram_wdata  = q_wdata;
        end else if (state == ST_FILL && mem_rd_valid) begin
            ram_we = 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nxt = ST_LOOKUP;
            ST_LOOKUP: begin
                if (q_write)      state_nxt = ST_WRITE;
                else if (cam_hit) state_nxt = ST_DONE;
                else              state_nxt = ST_FILL;
            end
            ST_FILL:   if (fill_last) state_nxt = ST_DONE;
            ST_WRITE:  state_nxt = ST_DONE;
            ST_DONE:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        mem_rd_req = 1'b0;
        mem_wr_en  = 1'b0;
        resp_valid = 1'b0;
        unique case (state)
            ST_IDLE:   req_ready  = 1'b1;
            ST_LOOKUP: ;
            ST_FILL:   mem_rd_req = 1'b1;
            ST_WRITE:  mem_wr_en  = 1'b1;
            ST_DONE:   resp_valid = 1'b1;
            default:   ;
        endcase
    end

    assign mem_rd_addr = {q_tag, fill_cnt};
    assign mem_wr_addr = {q_tag, q_off};
    assign mem_wr_data = q_wdata;
    assign resp_hit    = r_hit;
    assign resp_repl   = r_repl;
    assign resp_entry  = r_entry;
    assign resp_rdata  = r_rdata;

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write   <= 1'b0;
            q_tag     <= '0;
            q_off     <= '0;
            q_wdata   <= '0;
            valid_vec <= '0;
            tag_arr   <= '0;
            fill_cnt  <= '0;
            tgt_entry <= '0;
            r_hit     <= 1'b0;
            r_repl    <= 1'b0;
            r_entry   <= '0;
            r_rdata   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_write <= req_write;
                        q_tag   <= req_addr[ADDR_W-1:OFF_W];
                        q_off   <= req_addr[OFF_W-1:0];
                        q_wdata <= req_wdata;
                    end
                end
                ST_LOOKUP: begin
                    r_hit   <= cam_hit;
                    r_repl  <= 1'b0;
                    r_entry <= cam_hit ? cam_idx : '0;
                    if (q_write) begin
                        r_rdata <= q_wdata;
                    end else if (cam_hit) begin
                        r_rdata <= ram_rdata;
                    end else begin
                        tgt_entry <= vic_idx;
                        r_entry   <= vic_idx;
                        r_repl    <= vic_evict;
                        fill_cnt  <= '0;
                    end
                end
                ST_FILL: begin
                    if (mem_rd_valid) begin
                        if (fill_cnt == q_off) begin
                            r_rdata <= mem_rd_data;
                        end
                        fill_cnt <= fill_cnt + 1'b1;
                        if (&fill_cnt) begin
                            valid_vec[tgt_entry] <= 1'b1;
                            tag_arr[tgt_entry]   <= q_tag;
                        end
                    end
                end
                ST_WRITE: ;
                ST_DONE:  ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/assoc_fifo_cache_chk.sv
module assoc_fifo_cache_chk #(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_repl,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_en
);

    localparam int OFF_W = ADDR_W - TAG_W;

    // R11: response is a single-cycle pulse
    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11: accepted request makes the block busy
    assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: eviction is only reported on a miss
    assert_repl_only_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_repl) |-> !resp_hit);

    // R7: fill address held while memory has not returned the word
    assert_fill_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R7: fill address steps by one word after each accepted word
    assert_fill_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid && (mem_rd_addr[OFF_W-1:0] != '1))
        |=> (mem_rd_req && (mem_rd_addr == $past(mem_rd_addr) + 1'b1)));

    // R8: write-through beat is single and followed by the response
    assert_wr_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> (!mem_wr_en && resp_valid));

    // R8: fill and write-through never overlap
    assert_no_rd_wr_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_en));

endmodule

bind assoc_fifo_cache assoc_fifo_cache_chk #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_hit     (resp_hit),
    .resp_repl    (resp_repl),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_en    (mem_wr_en)
);

// File: tb/assoc_fifo_cache_tb_top.sv
`timescale 1ns/1ps
module assoc_fifo_cache_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        resp_valid, resp_hit, resp_repl;
    logic [1:0]  resp_entry;
    logic [7:0]  resp_rdata;
    logic        mem_rd_req;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [7:0]  mem_rd_data = '0;
    logic        mem_wr_en;
    logic [15:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;

    int checks = 0;
    int fails  = 0;

    // memory model state
    logic [7:0]  mem_arr [65536];
    int          rd_cnt, wr_cnt, fill_err;
    logic [15:0] rd_prev, last_wr_addr;
    logic [7:0]  last_wr_data;
    int          busy_ready, long_pulse;

    // last response
    logic       o_hit, o_repl;
    logic [1:0] o_entry;
    logic [7:0] o_data;

    always #4 clk = ~clk;

    assoc_fifo_cache dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_repl(resp_repl),
        .resp_entry(resp_entry), .resp_rdata(resp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [7:0] seed_val(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
    endfunction

    // main memory model, sampled away from the active edge
    always @(negedge clk) begin
        if (mem_wr_en) begin
            mem_arr[mem_wr_addr] = mem_wr_data;
            wr_cnt++;
            last_wr_addr = mem_wr_addr;
            last_wr_data = mem_wr_data;
        end
        if (mem_rd_req) begin
            if (rd_cnt == 0) begin
                if (mem_rd_addr[3:0] != 4'h0) fill_err++;
            end else if (mem_rd_addr != rd_prev + 16'd1) begin
                fill_err++;
            end
            rd_prev = mem_rd_addr;
            rd_cnt++;
        end
        mem_rd_valid = mem_rd_req;
        mem_rd_data  = mem_arr[mem_rd_addr];
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [7:0] d);
        int guard;
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; fill_err = 0; busy_ready = 0; long_pulse = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!resp_valid && guard < 200) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            guard++;
        end
        o_hit = resp_hit; o_repl = resp_repl; o_entry = resp_entry; o_data = resp_rdata;
        @(negedge clk);
        if (resp_valid) long_pulse++;
    endtask

    task automatic expect_read(input logic [15:0] a, input bit hit, input int ent,
                               input bit rep, input logic [7:0] dat, input string rq);
        access(1'b0, a, 8'h00);
        check(o_hit == hit, rq, $sformatf("hit @%h", a), o_hit, hit);
        check(o_entry == 2'(ent), rq, $sformatf("entry @%h", a), o_entry, ent);
        check(o_repl == rep, rq, $sformatf("repl @%h", a), o_repl, rep);
        check(o_data == dat, rq, $sformatf("data @%h", a), o_data, dat);
        check(rd_cnt == (hit ? 0 : 16), "R7", $sformatf("fill words @%h", a), rd_cnt, hit ? 0 : 16);
    endtask

    task automatic t_reset;
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        check(mem_rd_req == 1'b0 && mem_wr_en == 1'b0, "R1", "mem idle after reset",
              {mem_rd_req, mem_wr_en}, 0);
    endtask

    task automatic t_sequence;
        // R1/R4: first read goes into entry 0 without eviction
        expect_read(16'h010A, 0, 0, 0, seed_val(16'h010A), "R10_R4");
        check(fill_err == 0, "R7", "fill order", fill_err, 0);
        expect_read(16'h011A, 0, 1, 0, seed_val(16'h011A), "R10_R4");
        expect_read(16'h012F, 0, 2, 0, seed_val(16'h012F), "R10_R4");
        expect_read(16'h011B, 1, 1, 0, seed_val(16'h011B), "R10_R2_R3");
        expect_read(16'h023F, 0, 3, 0, seed_val(16'h023F), "R10_R4");
        expect_read(16'h012C, 1, 2, 0, seed_val(16'h012C), "R10_R3");
        expect_read(16'h030F, 0, 0, 1, seed_val(16'h030F), "R10_R5");
        check(fill_err == 0, "R7", "fill order on replace", fill_err, 0);
    endtask

    task automatic t_hits_keep_order;
        // entry 1 (tag 011) is the oldest; hitting it must not protect it (R6)
        expect_read(16'h0110, 1, 1, 0, seed_val(16'h0110), "R6");
        expect_read(16'h011F, 1, 1, 0, seed_val(16'h011F), "R6");
        expect_read(16'h0405, 0, 1, 1, seed_val(16'h0405), "R6_R5");
        expect_read(16'h0123, 1, 2, 0, seed_val(16'h0123), "R6");
    endtask

    task automatic t_write_hit;
        access(1'b1, 16'h0127, 8'hA5);
        check(o_hit == 1'b1 && o_entry == 2'd2, "R8", "write hit entry", {o_hit, o_entry}, 3'b110);
        check(wr_cnt == 1, "R8", "write-through beats", wr_cnt, 1);
        check(last_wr_addr == 16'h0127 && last_wr_data == 8'hA5, "R8", "write-through addr/data",
              {last_wr_addr, last_wr_data}, 24'h0127A5);
        expect_read(16'h0127, 1, 2, 0, 8'hA5, "R8");
    endtask

    task automatic t_write_miss;
        access(1'b1, 16'h0555, 8'h3C);
        check(o_hit == 1'b0 && o_repl == 1'b0, "R9", "write miss flags", {o_hit, o_repl}, 0);
        check(wr_cnt == 1 && last_wr_addr == 16'h0555 && last_wr_data == 8'h3C, "R9",
              "write miss memory", {last_wr_addr, last_wr_data}, 24'h05553C);
        check(rd_cnt == 0, "R9", "no fill on write miss", rd_cnt, 0);
        // no allocation and pointer still at entry 2
        expect_read(16'h0555, 0, 2, 1, 8'h3C, "R9");
        expect_read(16'h0127, 0, 3, 1, 8'hA5, "R9_R6");
    endtask

    task automatic t_handshake;
        expect_read(16'h0700, 0, 0, 1, seed_val(16'h0700), "R11");
        check(busy_ready == 0, "R11", "ready while busy", busy_ready, 0);
        check(long_pulse == 0, "R11", "resp pulse width", long_pulse, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 65536; i++) mem_arr[i] = seed_val(i);
        rd_cnt = 0; wr_cnt = 0; fill_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sequence();
        t_hits_keep_order();
        t_write_hit();
        t_write_miss();
        t_handshake();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule